// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block predicts the next fetch address in the fetch stage, before the fetched instruction has been decoded. It keeps a direct-mapped table of 2^k entries. Each entry holds a valid flag, the complete address of a control-transfer instruction and the address that instruction last jumped to. A fetch address whose full value matches a valid entry is redirected to the stored target. Any other address falls through to the sequential address, PC+4.

After a branch or jump executes, the resolution port reports its address, whether it really was a control transfer, whether it was taken, its real target, and the next PC that fetch used. The block answers in the same cycle. It says whether that next PC was wrong and gives the correct one. In the following cycle it allocates or overwrites an entry for a taken transfer, or drops the entry of a branch that went the other way.

Decode, direction prediction and the flushing of wrong-path work belong to other blocks.

Top module: `btb_direct`

## Requirements
- R1: After reset every entry is invalid, so every fetch address misses and gets PC+4 as next PC.
- R2: The entry index is PC bits [k+1:2]. A hit needs the stored address to equal all bits of the fetch PC, so an address that shares the index but differs in upper bits misses and gets PC+4.
- R3: On a hit, `fetch_hit` is 1 and `fetch_npc` is the stored target of the matching entry.
- R4: A resolution with `res_valid`=1, `res_is_ctrl`=1 and `res_taken`=1 writes {valid, `res_pc`, `res_target`} to its index. Lookups see the new contents from the next cycle on. This replaces any older entry at that index, and the older target is lost.
- R5: A resolution with `res_is_ctrl`=0, or a not-taken one whose address does not match the valid entry at its index, changes no entry.
- R6: A not-taken control-transfer resolution whose address matches a valid entry clears that entry's valid flag, so the next lookup of that address misses.
- R7: The correct PC is `res_target` if taken and `res_pc`+4 otherwise. `res_mispredict` is 1 in the same cycle exactly when `res_valid`=1 and `res_pred_npc` differs from the correct PC, and is 0 when `res_valid`=0.
- R8: A lookup in the same cycle as an update to the same index returns the contents from before the update.
- R9: Lookups never change the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched |
| fetch_hit | output | 1 | Fetch address matched a valid entry |
| fetch_npc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | A resolution is presented this cycle |
| res_pc | input | PC_W | Address of the resolved instruction |
| res_is_ctrl | input | 1 | Resolved instruction is a branch or jump |
| res_taken | input | 1 | Resolved transfer was taken |
| res_target | input | PC_W | Real target of the resolved transfer |
| res_pred_npc | input | PC_W | Next PC that fetch used after this instruction |
| res_mispredict | output | 1 | Fetch next PC was wrong |
| res_correct_pc | output | PC_W | Next PC the instruction really needs |

## Verification
The assertions assume that reset is held low for at least one clock edge. They also assume that at most one resolution arrives per cycle, and that its fields are stable around the clock edge.

The bench drives every resolution at a falling edge and holds it for exactly one rising edge. It only presents `res_is_ctrl`=0 together with `res_taken`=0, so each resolution stays inside those assumptions. A small instance with sixteen entries allows every index to be filled, aliased, overwritten and cleared, and the expected values come from address arithmetic.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Table action decided by the resolution path.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_WRITE = 2'd1,
        ACT_CLEAR = 2'd2
    } upd_act_e;

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PC_W-1:0]  rd_tag,
    output logic [PC_W-1:0]  rd_tgt,
    input  logic [IDX_W-1:0] chk_idx,
    output logic             chk_valid,
    output logic [PC_W-1:0]  chk_tag,
    input  upd_act_e         act,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PC_W-1:0]  wr_tag,
    input  logic [PC_W-1:0]  wr_tgt
);

    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0] valid;
    } vstate_t;

    vstate_t          state_d, state_q;
    logic [PC_W-1:0]  tag_q [ENTRIES];
    logic [PC_W-1:0]  tgt_q [ENTRIES];

    // Reads come from registered contents, so a same-cycle update is not visible.
    assign rd_valid  = state_q.valid[rd_idx];
    assign rd_tag    = tag_q[rd_idx];
    assign rd_tgt    = tgt_q[rd_idx];
    assign chk_valid = state_q.valid[chk_idx];
    assign chk_tag   = tag_q[chk_idx];

    always_comb begin
        state_d = state_q;
        case (act)
            ACT_WRITE: state_d.valid[wr_idx] = 1'b1;
            ACT_CLEAR: state_d.valid[wr_idx] = 1'b0;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && act == ACT_WRITE) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> state_q.valid == '0); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_WRITE |=> state_q.valid[$past(wr_idx)]
                              && tag_q[$past(wr_idx)] == $past(wr_tag)
                              && tgt_q[$past(wr_idx)] == $past(wr_tgt)); // R4

    AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_CLEAR |=> !state_q.valid[$past(wr_idx)]); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_NONE |=> $stable(state_q.valid)); // R5

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 7
) (
    input  logic [PC_W-1:0]  fetch_pc,
    output logic [IDX_W-1:0] rd_idx,
    input  logic             rd_valid,
    input  logic [PC_W-1:0]  rd_tag,
    input  logic [PC_W-1:0]  rd_tgt,
    output logic             hit,
    output logic [PC_W-1:0]  npc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic [PC_W-1:0] seq_pc;

    assign rd_idx = fetch_pc[IDX_W+1:2];
    assign seq_pc = fetch_pc + STEP;

    always_comb begin
        hit = rd_valid && (rd_tag == fetch_pc);
        npc = hit ? rd_tgt : seq_pc;
    end

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [PC_W-1:0]  res_pc,
    input  logic             res_is_ctrl,
    input  logic             res_taken,
    input  logic [PC_W-1:0]  res_target,
    input  logic [PC_W-1:0]  res_pred_npc,
    output logic [IDX_W-1:0] ent_idx,
    input  logic             ent_valid,
    input  logic [PC_W-1:0]  ent_tag,
    output upd_act_e         act,
    output logic             mispredict,
    output logic [PC_W-1:0]  correct_pc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic taken_xfer;
    logic own_entry;

    assign ent_idx    = res_pc[IDX_W+1:2];
    assign taken_xfer = res_is_ctrl && res_taken;
    assign own_entry  = ent_valid && (ent_tag == res_pc);

    always_comb begin
        correct_pc = taken_xfer ? res_target : res_pc + STEP;
        mispredict = res_valid && (res_pred_npc != correct_pc);
        act        = ACT_NONE;
        if (res_valid && res_is_ctrl) begin
            if (res_taken) begin
                act = ACT_WRITE;
            end else if (own_entry) begin
                act = ACT_CLEAR;
            end
        end
    end

    AST_QUIET_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> act == ACT_NONE && !mispredict); // R7

    AST_NONCTRL_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_is_ctrl |-> act == ACT_NONE); // R5

endmodule

// File: rtl/btb_direct.sv
module btb_direct
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            fetch_hit,
    output logic [PC_W-1:0] fetch_npc,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_is_ctrl,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    input  logic [PC_W-1:0] res_pred_npc,
    output logic            res_mispredict,
    output logic [PC_W-1:0] res_correct_pc
);

    logic [IDX_W-1:0] rd_idx;
    logic             rd_valid;
    logic [PC_W-1:0]  rd_tag;
    logic [PC_W-1:0]  rd_tgt;
    logic [IDX_W-1:0] chk_idx;
    logic             chk_valid;
    logic [PC_W-1:0]  chk_tag;
    upd_act_e         act;

    btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lookup (
        .fetch_pc (fetch_pc),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .hit      (fetch_hit),
        .npc      (fetch_npc)
    );

    btb_resolve #(.PC_W(PC_W), .IDX_W(IDX_W)) u_resolve (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_valid    (res_valid),
        .res_pc       (res_pc),
        .res_is_ctrl  (res_is_ctrl),
        .res_taken    (res_taken),
        .res_target   (res_target),
        .res_pred_npc (res_pred_npc),
        .ent_idx      (chk_idx),
        .ent_valid    (chk_valid),
        .ent_tag      (chk_tag),
        .act          (act),
        .mispredict   (res_mispredict),
        .correct_pc   (res_correct_pc)
    );

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_tgt    (rd_tgt),
        .chk_idx   (chk_idx),
        .chk_valid (chk_valid),
        .chk_tag   (chk_tag),
        .act       (act),
        .wr_idx    (chk_idx),
        .wr_tag    (res_pc),
        .wr_tgt    (res_target)
    );

    AST_HIT_MEANS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> fetch_pc[IDX_W+1:2] == rd_idx && fetch_npc == rd_tgt); // R3

endmodule

// File: tb/btb_direct_tb.sv
module btb_direct_tb;

    localparam int PC_W  = 32;
    localparam int IDX_W = 4;
    localparam int N     = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            fetch_hit;
    logic [PC_W-1:0] fetch_npc;
    logic            res_valid = 1'b0;
    logic [PC_W-1:0] res_pc = '0;
    logic            res_is_ctrl = 1'b0;
    logic            res_taken = 1'b0;
    logic [PC_W-1:0] res_target = '0;
    logic [PC_W-1:0] res_pred_npc = '0;
    logic            res_mispredict;
    logic [PC_W-1:0] res_correct_pc;

    int checks = 0;
    int errors = 0;

    // Expected table contents, kept from the requirements
    logic            mv [N];
    logic [PC_W-1:0] mt [N];
    logic [PC_W-1:0] mg [N];

    always #2 clk = ~clk;

    btb_direct #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_pc       (fetch_pc),
        .fetch_hit      (fetch_hit),
        .fetch_npc      (fetch_npc),
        .res_valid      (res_valid),
        .res_pc         (res_pc),
        .res_is_ctrl    (res_is_ctrl),
        .res_taken      (res_taken),
        .res_target     (res_target),
        .res_pred_npc   (res_pred_npc),
        .res_mispredict (res_mispredict),
        .res_correct_pc (res_correct_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [PC_W-1:0] act,
                       input logic [PC_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return int'((pc >> 2) % N);
    endfunction

    // Lookup and compare against the expected table.
    task automatic look(input logic [PC_W-1:0] pc, input string req);
        int  i;
        bit  eh;
        logic [PC_W-1:0] en;
        @(negedge clk);
        fetch_pc = pc;
        #1;
        i  = idx_of(pc);
        eh = mv[i] && (mt[i] == pc);
        en = eh ? mg[i] : pc + 4;
        chk(fetch_hit == eh, req, {31'd0, fetch_hit}, {31'd0, eh});
        chk(fetch_npc == en, req, fetch_npc, en);
    endtask

    // One resolution, held for a single rising edge; expected table updated after it.
    task automatic resolve(input logic [PC_W-1:0] pc, input bit ctrl, input bit tk,
                           input logic [PC_W-1:0] tgt, input logic [PC_W-1:0] pred);
        int i;
        logic [PC_W-1:0] corr;
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_is_ctrl = ctrl; res_taken = tk;
        res_target = tgt; res_pred_npc = pred;
        #1;
        corr = (ctrl && tk) ? tgt : pc + 4;
        chk(res_correct_pc == corr, "R7 correct pc", res_correct_pc, corr);
        chk(res_mispredict == (pred != corr), "R7 mispredict",
            {31'd0, res_mispredict}, {31'd0, pred != corr});
        @(negedge clk);
        res_valid = 1'b0; res_is_ctrl = 1'b0; res_taken = 1'b0;
        i = idx_of(pc);
        if (ctrl && tk) begin
            mv[i] = 1'b1; mt[i] = pc; mg[i] = tgt;
        end else if (ctrl && mv[i] && mt[i] == pc) begin
            mv[i] = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mv[i] = 1'b0; mt[i] = '0; mg[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        for (int i = 0; i < N; i++) look(32'h1000 + i * 4, "R1 empty after reset");

        // R7 with no resolution presented
        @(negedge clk);
        res_pred_npc = 32'hdead_0000; res_pc = 32'h10; #1;
        chk(res_mispredict == 1'b0, "R7 idle quiet", {31'd0, res_mispredict}, 32'd0);

        // R4: fill all entries with taken branches (fetch used PC+4)
        for (int i = 0; i < N; i++)
            resolve(32'h1000 + i * 4, 1'b1, 1'b1, 32'h8000 + i * 16, 32'h1000 + i * 4 + 4);
        // R3: every filled entry hits with its target
        for (int i = 0; i < N; i++) look(32'h1000 + i * 4, "R3 hit returns target");
        // R2: aliases differ in upper bits only and miss
        for (int i = 0; i < N; i++) look(32'h1000 + i * 4 + N * 4, "R2 alias misses");

        // R5: non-control resolution leaves table alone
        resolve(32'h1000, 1'b0, 1'b0, 32'h0, 32'h1004);
        look(32'h1000, "R5 non-control no update");
        // R5: not-taken alias that does not own the entry
        resolve(32'h1000 + N * 4, 1'b1, 1'b0, 32'h0, 32'h1000 + N * 4 + 4);
        look(32'h1000, "R5 foreign not-taken no update");

        // R4: overwrite idx1 with a new target, fetch used the old one
        resolve(32'h1004, 1'b1, 1'b1, 32'h9abc, 32'h8010);
        look(32'h1004, "R4 overwrite new target");

        // R6: idx2 branch resolves not-taken after a redirect
        resolve(32'h1008, 1'b1, 1'b0, 32'h0, 32'h8020);
        look(32'h1008, "R6 not-taken clears entry");
        chk(fetch_npc == 32'h100c, "R6 falls through", fetch_npc, 32'h100c);

        // R4/R2: alias allocation displaces the old owner of idx0
        resolve(32'h1000 + N * 4, 1'b1, 1'b1, 32'h7770, 32'h1000 + N * 4 + 4);
        look(32'h1000, "R4 displaced owner misses");
        look(32'h1000 + N * 4, "R4 alias now hits");

        // R8: same-cycle lookup and update to idx3
        @(negedge clk);
        fetch_pc = 32'h100c;
        res_valid = 1'b1; res_pc = 32'h100c; res_is_ctrl = 1'b1; res_taken = 1'b1;
        res_target = 32'h5550; res_pred_npc = 32'h8030;
        #1;
        chk(fetch_hit && fetch_npc == 32'h8030, "R8 old contents same cycle",
            fetch_npc, 32'h8030);
        @(negedge clk);
        res_valid = 1'b0; res_is_ctrl = 1'b0; res_taken = 1'b0;
        mg[3] = 32'h5550;
        #1;
        chk(fetch_npc == 32'h5550, "R8 new contents next cycle", fetch_npc, 32'h5550);

        // R9: repeated lookups leave every entry as expected
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < N; i++) look(32'h1000 + i * 4, "R9 lookups no effect");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule